// File: doc/BRIEF.md
# Bit-Branch / Carry-Complement Hazard Monitor

This block watches the opcodes an 8051-compatible core retires, one per retire strobe. It raises a hazard when a carry-complement instruction retires as the very next instruction after a bit-test conditional branch. The branch can be jump-if-set, jump-if-clear, or jump-if-set-and-clear. The hazard is raised whether or not the branch was taken. Each hazard produces a one-cycle pulse, sets a sticky flag and advances an occurrence counter that saturates.

The block also carries a model of the carry flag. When fault emulation is enabled, this model reproduces the faulty carry behaviour. On a hazard, a carry of 1 stays at 1 after the complement, while a carry of 0 still becomes 1. Software workarounds can therefore be run against the faulty behaviour in simulation. When fault emulation is disabled, the model always complements the carry correctly.

Top module: `hz_monitor`

## Requirements
- R1: A hazard pulse is raised when a retired carry-complement (opcode 0xB3) directly follows a retired bit-test branch. The bit-test branch opcodes are 0x10, 0x20 and 0x30. `hazard_pulse` is high in the same cycle as that carry-complement retirement and in no other cycle.
- R2: The hazard pulse is raised whatever value `br_taken` had for the preceding branch.
- R3: Any other opcode retired between the branch and the carry-complement clears the branch history, and no hazard pulse follows. A retired carry-complement also clears the history.
- R4: Cycles with `retire_vld` low leave the branch history unchanged. A branch, then idle cycles, then a carry-complement still raises a hazard.
- R5: When `fault_en` is 1 and a hazard is present, a carry-in of 1 gives `carry_out` = 1.
- R6: A retired carry-complement with carry-in 0 always gives `carry_out` = 1.
- R7: A carry-complement with no hazard, or with `fault_en` 0, gives `carry_out` = NOT `carry_in`. Any other retired opcode, and any idle cycle, gives `carry_out` = `carry_in`.
- R8: `hazard_sticky` is set on the clock edge that ends a hazard cycle. It stays set until a cycle with `clr_sticky` high and no hazard. When a hazard and `clr_sticky` occur in the same cycle, the flag is left set.
- R9: `hazard_cnt` increments by one on each hazard and holds at all-ones instead of wrapping.
- R10: A synchronous active-low reset clears the branch history, the sticky flag and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_sticky | input | 1 | Synchronous clear of the sticky flag |
| retire_vld | input | 1 | An opcode retires this cycle |
| op_code | input | 8 | Retired opcode byte |
| br_taken | input | 1 | Outcome of a retired branch (has no effect on detection) |
| carry_in | input | 1 | Carry flag before the instruction executes |
| fault_en | input | 1 | Enables fault emulation in the carry model |
| hazard_pulse | output | 1 | Hazard in the current retirement |
| hazard_sticky | output | 1 | At least one hazard since the last clear or reset |
| hazard_cnt | output | CNT_W | Saturating count of hazards |
| carry_out | output | 1 | Modelled carry after execution |

## Verification
The bench builds the block with `CNT_W` = 4, so the counter saturates after fifteen hazards. Saturation is therefore reached inside a short run.

The bench sweeps six preceding opcodes against zero, one or two idle cycles, both branch outcomes, both carry values and both fault settings. This covers every combination of history, idle gap and carry model. Further sequences cover a clear that coincides with a hazard, back-to-back branches, and a reset that falls between a branch and its carry-complement.

// File: rtl/hz_pkg.sv
// Package: opcode constants and decode helpers shared by the hazard monitor.
// Assumes single-byte opcode classification only; operand bytes are never seen.
package hz_pkg;
    localparam logic [7:0] OP_JBC  = 8'h10;
    localparam logic [7:0] OP_JB   = 8'h20;
    localparam logic [7:0] OP_JNB  = 8'h30;
    localparam logic [7:0] OP_CPLC = 8'hB3;

    // True for any of the three bit-test conditional branches.
    function automatic logic is_bit_branch(input logic [7:0] op);
        return (op == OP_JBC) || (op == OP_JB) || (op == OP_JNB);
    endfunction

    // True for the carry-complement opcode.
    function automatic logic is_carry_cpl(input logic [7:0] op);
        return op == OP_CPLC;
    endfunction
endpackage

// File: rtl/hz_decode.sv
// Module: classifies a retired opcode into bit-branch / carry-complement.
// Assumes op_code is meaningful only when retire_vld is high; outputs are gated by it.
module hz_decode
    import hz_pkg::*;
(
    input  logic       retire_vld,
    input  logic [7:0] op_code,
    output logic       ret_bbr,
    output logic       ret_cpl
);
    // Gate classification with the retire strobe.
    always_comb begin
        ret_bbr = retire_vld && is_bit_branch(op_code);
        ret_cpl = retire_vld && is_carry_cpl(op_code);
    end
endmodule

// File: rtl/hz_history.sv
// Module: remembers whether the last retired instruction was a bit-test branch
// and flags a carry-complement that immediately follows one.
// Assumes synchronous active-low reset; idle cycles leave the history untouched.
module hz_history (
    input  logic clk,
    input  logic rst_n,
    input  logic retire_vld,
    input  logic ret_bbr,
    input  logic ret_cpl,
    output logic hazard
);
    logic prev_bbr_q;

    // Update history only on retirements.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_bbr_q <= 1'b0;
        else if (retire_vld)
            prev_bbr_q <= ret_bbr;
    end

    // Hazard is the current carry-complement behind a remembered branch.
    always_comb hazard = ret_cpl && prev_bbr_q;
endmodule

// File: rtl/hz_tally.sv
// Module: sticky hazard flag and saturating hazard counter.
// Assumes a hazard arriving with a clear keeps the flag set.
module hz_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hazard,
    input  logic             clr_sticky,
    output logic             sticky,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             sticky_q;
    logic [CNT_W-1:0] count_q;

    // Sticky flag: set by hazard, cleared by clr_sticky otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sticky_q <= 1'b0;
        else if (hazard)
            sticky_q <= 1'b1;
        else if (clr_sticky)
            sticky_q <= 1'b0;
    end

    // Counter: advance on hazard, hold at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (hazard && (count_q != CNT_MAX))
            count_q <= count_q + 1'b1;
    end

    assign sticky = sticky_q;
    assign count  = count_q;
endmodule

// File: rtl/hz_carry.sv
// Module: combinational carry-flag model with optional fault emulation.
// Assumes carry_in is the flag before execution of the retiring instruction.
module hz_carry (
    input  logic ret_cpl,
    input  logic hazard,
    input  logic fault_en,
    input  logic carry_in,
    output logic carry_out
);
    // Complement on carry-complement; a faulted hazard cannot clear a set carry.
    always_comb begin
        if (!ret_cpl)
            carry_out = carry_in;
        else if (hazard && fault_en && carry_in)
            carry_out = 1'b1;
        else
            carry_out = ~carry_in;
    end
endmodule

// File: rtl/hz_monitor.sv
// Module: top of the bit-branch / carry-complement hazard monitor.
// Assumes one retirement at most per cycle; br_taken does not affect detection.
module hz_monitor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_sticky,
    input  logic             retire_vld,
    input  logic [7:0]       op_code,
    input  logic             br_taken,
    input  logic             carry_in,
    input  logic             fault_en,
    output logic             hazard_pulse,
    output logic             hazard_sticky,
    output logic [CNT_W-1:0] hazard_cnt,
    output logic             carry_out
);
    logic ret_bbr;
    logic ret_cpl;
    logic hazard;

    hz_decode u_dec (
        .retire_vld (retire_vld),
        .op_code    (op_code),
        .ret_bbr    (ret_bbr),
        .ret_cpl    (ret_cpl)
    );

    hz_history u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .retire_vld (retire_vld),
        .ret_bbr    (ret_bbr),
        .ret_cpl    (ret_cpl),
        .hazard     (hazard)
    );

    hz_tally #(.CNT_W(CNT_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .hazard     (hazard),
        .clr_sticky (clr_sticky),
        .sticky     (hazard_sticky),
        .count      (hazard_cnt)
    );

    hz_carry u_carry (
        .ret_cpl    (ret_cpl),
        .hazard     (hazard),
        .fault_en   (fault_en),
        .carry_in   (carry_in),
        .carry_out  (carry_out)
    );

    // Drive the hazard pulse port straight from the history stage.
    assign hazard_pulse = hazard;
endmodule

// File: rtl/hz_monitor_chk.sv
// Checker: port-level properties of hz_monitor, attached with bind.
module hz_monitor_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_sticky,
    input logic             retire_vld,
    input logic [7:0]       op_code,
    input logic             br_taken,
    input logic             carry_in,
    input logic             fault_en,
    input logic             hazard_pulse,
    input logic             hazard_sticky,
    input logic [CNT_W-1:0] hazard_cnt,
    input logic             carry_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    a_r1_pulse_on_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_pulse |-> (retire_vld && op_code == 8'hB3));

    a_r2_taken_irrelevant: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_pulse && br_taken) |-> retire_vld);

    a_r5_fault_holds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_pulse && fault_en && carry_in) |-> carry_out);

    a_r6_zero_to_one: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && op_code == 8'hB3 && !carry_in) |-> carry_out);

    a_r7_plain_complement: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && op_code == 8'hB3 && (!hazard_pulse || !fault_en)) |-> (carry_out == !carry_in));

    a_r8_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hazard_pulse |=> hazard_sticky);

    a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_cnt == CNT_MAX) |=> (hazard_cnt == CNT_MAX || !rst_n));

    a_r9_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!hazard_pulse && rst_n) |=> ($stable(hazard_cnt) || !rst_n));
endmodule

bind hz_monitor hz_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_sticky    (clr_sticky),
    .retire_vld    (retire_vld),
    .op_code       (op_code),
    .br_taken      (br_taken),
    .carry_in      (carry_in),
    .fault_en      (fault_en),
    .hazard_pulse  (hazard_pulse),
    .hazard_sticky (hazard_sticky),
    .hazard_cnt    (hazard_cnt),
    .carry_out     (carry_out)
);

// File: tb/tb_hz_monitor.sv
module tb_hz_monitor;
    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n, clr_sticky, retire_vld, br_taken, carry_in, fault_en;
    logic [7:0]       op_code;
    logic             hazard_pulse, hazard_sticky, carry_out;
    logic [CNT_W-1:0] hazard_cnt;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    bit m_prev = 0;
    bit m_sticky = 0;
    int m_cnt = 0;

    always #10 clk = ~clk;

    hz_monitor #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .clr_sticky(clr_sticky), .retire_vld(retire_vld),
        .op_code(op_code), .br_taken(br_taken), .carry_in(carry_in), .fault_en(fault_en),
        .hazard_pulse(hazard_pulse), .hazard_sticky(hazard_sticky),
        .hazard_cnt(hazard_cnt), .carry_out(carry_out)
    );

    function automatic bit is_bb(input logic [7:0] op);
        return op == 8'h10 || op == 8'h20 || op == 8'h30;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, check combinational outputs, then registered ones.
    task automatic step(input bit rn, input bit vld, input logic [7:0] op, input bit tk,
                        input bit c, input bit fe, input bit clr, input string ptag);
        bit hz, exp_c;
        rst_n = rn; retire_vld = vld; op_code = op; br_taken = tk;
        carry_in = c; fault_en = fe; clr_sticky = clr;
        #1;
        hz = rn && vld && op == 8'hB3 && m_prev;
        if (rn) begin
            chk(ptag, hazard_pulse, hz);
            if (vld && op == 8'hB3) begin
                exp_c = (hz && fe && c) ? 1'b1 : !c;
                chk((hz && fe && c) ? "R5" : (!c ? "R6" : "R7"), carry_out, exp_c);
            end else begin
                chk("R7", carry_out, c);
            end
        end
        @(negedge clk);
        if (!rn) begin
            m_prev = 0; m_sticky = 0; m_cnt = 0;
        end else begin
            if (vld) m_prev = is_bb(op);
            if (hz) m_sticky = 1; else if (clr) m_sticky = 0;
            if (hz && m_cnt != CMAX) m_cnt++;
        end
        chk(rn ? "R8" : "R10", hazard_sticky, m_sticky);
        chk(rn ? "R9" : "R10", hazard_cnt, m_cnt);
    endtask

    task automatic idle(input string ptag);
        step(1, 0, 8'hB3, 0, 1, 1, 0, ptag);
    endtask

    initial begin
        #2_000_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] ops [6];
        ops[0] = 8'h10; ops[1] = 8'h20; ops[2] = 8'h30;
        ops[3] = 8'hB3; ops[4] = 8'h00; ops[5] = 8'hC3;
        @(negedge clk);
        // R10: reset state
        step(0, 1, 8'h20, 0, 0, 0, 0, "R10");
        step(0, 0, 8'h00, 0, 0, 0, 0, "R10");
        // Sweep preceding opcode x idle gap x taken x carry x fault
        for (int p = 0; p < 6; p++)
            for (int g = 0; g < 3; g++)
                for (int tk = 0; tk < 2; tk++)
                    for (int c = 0; c < 2; c++)
                        for (int fe = 0; fe < 2; fe++) begin
                            step(1, 1, ops[p], tk[0], c[0], fe[0], 0, "R3");
                            for (int i = 0; i < g; i++) idle("R4");
                            step(1, 1, 8'hB3, 0, c[0], fe[0], 0,
                                 !is_bb(ops[p]) ? "R3" : (g > 0 ? "R4" : (tk != 0 ? "R2" : "R1")));
                        end
        // R8: clear without hazard drops the flag
        step(1, 1, 8'h00, 0, 0, 0, 1, "R8");
        idle("R8");
        // R8: clear together with a hazard keeps it set
        step(1, 1, 8'h30, 1, 0, 0, 0, "R1");
        step(1, 1, 8'hB3, 0, 1, 1, 1, "R1");
        // R1: back-to-back branches then complement
        step(1, 1, 8'h10, 0, 0, 0, 0, "R3");
        step(1, 1, 8'h20, 1, 0, 0, 0, "R3");
        step(1, 1, 8'hB3, 0, 1, 1, 0, "R1");
        // R3: complement after complement clears the history
        step(1, 1, 8'hB3, 0, 1, 1, 0, "R3");
        // R10: reset between branch and complement clears history
        step(1, 1, 8'h20, 0, 0, 0, 0, "R3");
        step(0, 0, 8'h00, 0, 0, 0, 0, "R10");
        step(1, 1, 8'hB3, 0, 1, 1, 0, "R10");
        step(1, 1, 8'h10, 0, 1, 1, 0, "R3");
        step(1, 1, 8'hB3, 1, 1, 1, 0, "R1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule